// File: doc/BRIEF.md
# Accumulator Middle-Word Logic Unit

This block is the bitwise logic stage of a small fixed-point DSP. The DSP has two 40-bit accumulators and two secondary registers. Each accumulator holds an 8-bit top part, a 16-bit middle word and a 16-bit bottom word. The block takes one 16-bit instruction from the 0011 opcode group, together with a snapshot of both accumulators and the high halves of both secondary registers. It applies AND, OR, XOR or bit inversion to the middle word of the chosen destination accumulator. It returns the whole destination accumulator with only that middle word replaced, and it returns a set of condition flags worked out from the 16-bit result alone.

Instruction bit 7 selects the operand form. When bit 7 is clear, the second operand is either the high half of a secondary register or the middle word of the other accumulator. When bit 7 is set, the instruction is a cross-accumulator XOR or an inversion. Bits 6..0 carry a side operation that this unit does not handle. Any code outside the decoded set returns a result marked illegal, and that result requests no write.

Instructions and operands enter on a valid/ready stream, and results leave on another. A result appears one cycle after its instruction is accepted. One result register sits between the two streams. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` is low, so nothing is lost or overwritten. An instruction can be accepted in the same cycle that the held result is taken.

Top module: `acc_mid_logic`

## Requirements
- R1: With bit 7 = 0, bits 15..12 = 0011 and bits 11..10 = 00, 01 or 10, the result middle word is XOR, AND or OR (in that order) of acc[d].mid and axh[s]. Here d is bit 8 and s is bit 9.
- R2: With bit 7 = 0 and bits 11..10 = 11, the result middle word is acc[d].mid AND acc[1-d].mid when bit 9 = 0, and acc[d].mid OR acc[1-d].mid when bit 9 = 1. Here d is bit 8.
- R3: With bit 7 = 1 and bits 11..9 = 000, the result middle word is acc[d].mid XOR acc[1-d].mid. With bit 7 = 1 and bits 11..9 = 001, the result middle word is the bitwise inverse of acc[d].mid.
- R4: Instruction bits 6..0 have no effect on any result field.
- R5: For a legal instruction, `out_acc` equals acc[d] with only bits 31..16 replaced. The top 8 bits and the bottom 16 bits are passed through unchanged, `out_dst` = d and `out_wr` = 1.
- R6: For a legal instruction, `out_zero` is 1 exactly when the 16-bit result is 0, and `out_sign` equals result bit 15. Both hold regardless of the other accumulator bits. `out_carry` and `out_ovf` are 0.
- R7: Any other code, including codes with bits 15..12 other than 0011, gives `out_illegal` = 1 with `out_wr` = 0. In that case `out_acc`, `out_dst` and all four flags are 0.
- R8: An instruction accepted at a clock edge (`in_valid` and `in_ready` both high) gives `out_valid` = 1 with its result after that edge.
- R9: `in_ready` = !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, every result output holds its value.
- R10: During and right after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_instr | input | 16 | Instruction word |
| in_acc0 | input | 40 | Accumulator 0 snapshot |
| in_acc1 | input | 40 | Accumulator 1 snapshot |
| in_ax0_hi | input | 16 | High half of secondary register 0 |
| in_ax1_hi | input | 16 | High half of secondary register 1 |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_wr | output | 1 | Write the result back to the destination accumulator |
| out_illegal | output | 1 | Instruction was not a decoded logic operation |
| out_dst | output | 1 | Destination accumulator index |
| out_acc | output | 40 | New destination accumulator value |
| out_zero | output | 1 | Result middle word is zero |
| out_sign | output | 1 | Result middle word bit 15 |
| out_carry | output | 1 | Carry flag, always cleared |
| out_ovf | output | 1 | Overflow flag, always cleared |

## Verification
Four behaviours are checked by assertions on every cycle:
- a stalled result stays frozen;
- an accepted instruction always yields a valid result on the next cycle;
- an illegal result never requests a write and carries no flags;
- the zero and sign flags always agree with the middle word of the registered accumulator, and the top and bottom slices pass through the execution stage.

The opcode mapping, operand routing by the s and d bits, the don't-care status of the extension field and the exact illegal set can only be shown by the bench's scenarios. The bench compares every output against a behavioural model on every clock, under both directed and randomly stalled traffic.

// File: rtl/acc_mid_logic_pkg.sv
package acc_mid_logic_pkg;
  localparam int INSTR_W = 16;
  localparam int EXT_W = 7;
  localparam logic [3:0] GROUP_CODE = 4'b0011;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2,
    OP_NOT = 2'd3
  } lop_e;

  typedef enum logic {
    SRC_AXH  = 1'b0,
    SRC_ACCM = 1'b1
  } lsrc_e;

  typedef struct packed {
    logic  legal;
    lop_e  op;
    lsrc_e src;
    logic  sel_s;
    logic  sel_d;
  } ldec_t;
endpackage

// File: rtl/acc_mid_logic_dec.sv
module acc_mid_logic_dec
  import acc_mid_logic_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ldec_t              dec
);
  logic unused_ext;
  assign unused_ext = ^instr[EXT_W-1:0];

  always_comb begin
    dec = '{legal: 1'b0, op: OP_AND, src: SRC_AXH, sel_s: instr[9], sel_d: instr[8]};
    if (instr[15:12] == GROUP_CODE) begin
      if (!instr[7]) begin
        dec.legal = 1'b1;
        case (instr[11:10])
          2'b00:   dec.op = OP_XOR;
          2'b01:   dec.op = OP_AND;
          2'b10:   dec.op = OP_OR;
          default: begin
            dec.src = SRC_ACCM;
            dec.op  = instr[9] ? OP_OR : OP_AND;
          end
        endcase
      end else if (instr[11:10] == 2'b00) begin
        dec.legal = 1'b1;
        dec.src   = SRC_ACCM;
        dec.op    = instr[9] ? OP_NOT : OP_XOR;
      end
    end
  end

  // R7: a word outside the group never decodes as legal
  always_comb begin
    if (instr[15:12] != GROUP_CODE)
      a_r7_foreign_group: assert (!dec.legal);
  end
endmodule

// File: rtl/acc_mid_logic_exec.sv
module acc_mid_logic_exec
  import acc_mid_logic_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int MID_W = 16,
  parameter int LO_W  = 16,
  localparam int ACC_W = HI_W + MID_W + LO_W
) (
  input  ldec_t             dec,
  input  logic [ACC_W-1:0]  acc0,
  input  logic [ACC_W-1:0]  acc1,
  input  logic [MID_W-1:0]  ax0_hi,
  input  logic [MID_W-1:0]  ax1_hi,
  output logic [MID_W-1:0]  res_mid,
  output logic [ACC_W-1:0]  new_acc
);
  localparam int NUM_ACC = 2;

  logic [ACC_W-1:0] acc_arr [NUM_ACC];
  logic [MID_W-1:0] mid_arr [NUM_ACC];
  logic [MID_W-1:0] axh_arr [NUM_ACC];
  logic [MID_W-1:0] opa, opb;

  assign acc_arr[0] = acc0;
  assign acc_arr[1] = acc1;
  assign axh_arr[0] = ax0_hi;
  assign axh_arr[1] = ax1_hi;

  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_slice
    assign mid_arr[gi] = acc_arr[gi][LO_W +: MID_W];
  end

  always_comb begin
    opa = mid_arr[dec.sel_d];
    opb = (dec.src == SRC_AXH) ? axh_arr[dec.sel_s] : mid_arr[~dec.sel_d];
    case (dec.op)
      OP_AND:  res_mid = opa & opb;
      OP_OR:   res_mid = opa | opb;
      OP_XOR:  res_mid = opa ^ opb;
      default: res_mid = ~opa;
    endcase
    new_acc = acc_arr[dec.sel_d];
    new_acc[LO_W +: MID_W] = res_mid;
  end

  // R5: top and bottom slices of the destination pass through
  always_comb begin
    a_r5_keep_edges: assert (new_acc[ACC_W-1 -: HI_W] == acc_arr[dec.sel_d][ACC_W-1 -: HI_W]
                          && new_acc[LO_W-1:0] == acc_arr[dec.sel_d][LO_W-1:0]);
  end
endmodule

// File: rtl/acc_mid_logic_flags.sv
module acc_mid_logic_flags #(
  parameter int MID_W = 16
) (
  input  logic [MID_W-1:0] res_mid,
  output logic             zero,
  output logic             sign,
  output logic             carry,
  output logic             ovf
);
  assign zero  = (res_mid == '0);
  assign sign  = res_mid[MID_W-1];
  assign carry = 1'b0;
  assign ovf   = 1'b0;
endmodule

// File: rtl/acc_mid_logic.sv
module acc_mid_logic
  import acc_mid_logic_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int MID_W = 16,
  parameter int LO_W  = 16,
  localparam int ACC_W = HI_W + MID_W + LO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [ACC_W-1:0]   in_acc0,
  input  logic [ACC_W-1:0]   in_acc1,
  input  logic [MID_W-1:0]   in_ax0_hi,
  input  logic [MID_W-1:0]   in_ax1_hi,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_wr,
  output logic               out_illegal,
  output logic               out_dst,
  output logic [ACC_W-1:0]   out_acc,
  output logic               out_zero,
  output logic               out_sign,
  output logic               out_carry,
  output logic               out_ovf
);
  ldec_t            dec;
  logic [MID_W-1:0] res_mid;
  logic [ACC_W-1:0] new_acc;
  logic             f_zero, f_sign, f_carry, f_ovf;
  logic             accept;

  acc_mid_logic_dec u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  acc_mid_logic_exec #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_exec (
    .dec     (dec),
    .acc0    (in_acc0),
    .acc1    (in_acc1),
    .ax0_hi  (in_ax0_hi),
    .ax1_hi  (in_ax1_hi),
    .res_mid (res_mid),
    .new_acc (new_acc)
  );

  acc_mid_logic_flags #(.MID_W(MID_W)) u_flags (
    .res_mid (res_mid),
    .zero    (f_zero),
    .sign    (f_sign),
    .carry   (f_carry),
    .ovf     (f_ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr      <= 1'b0;
      out_illegal <= 1'b0;
      out_dst     <= 1'b0;
      out_acc     <= '0;
      out_zero    <= 1'b0;
      out_sign    <= 1'b0;
      out_carry   <= 1'b0;
      out_ovf     <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_wr      <= dec.legal;
      out_illegal <= !dec.legal;
      out_dst     <= dec.legal ? dec.sel_d : 1'b0;
      out_acc     <= dec.legal ? new_acc : '0;
      out_zero    <= dec.legal && f_zero;
      out_sign    <= dec.legal && f_sign;
      out_carry   <= dec.legal && f_carry;
      out_ovf     <= dec.legal && f_ovf;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  a_r8_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_dst)
                                   && $stable(out_wr) && $stable(out_zero) && $stable(out_sign)));

  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wr && !out_zero && !out_sign && !out_carry && !out_ovf));

  a_r6_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr) |-> ((out_zero == (out_acc[LO_W +: MID_W] == '0))
                               && (out_sign == out_acc[LO_W + MID_W - 1])));
endmodule

// File: tb/acc_mid_logic_tb.sv
`timescale 1ns/1ps
module acc_mid_logic_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [39:0] in_acc0 = '0, in_acc1 = '0;
  logic [15:0] in_ax0_hi = '0, in_ax1_hi = '0;
  logic        out_valid, out_ready = 1'b1;
  logic        out_wr, out_illegal, out_dst;
  logic [39:0] out_acc;
  logic        out_zero, out_sign, out_carry, out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_mid_logic u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_acc0(in_acc0), .in_acc1(in_acc1),
    .in_ax0_hi(in_ax0_hi), .in_ax1_hi(in_ax1_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr(out_wr),
    .out_illegal(out_illegal), .out_dst(out_dst), .out_acc(out_acc),
    .out_zero(out_zero), .out_sign(out_sign), .out_carry(out_carry), .out_ovf(out_ovf)
  );

  // reference model state
  bit          m_have = 0;
  bit          m_wr, m_ill, m_dst, m_z, m_s;
  logic [39:0] m_acc;
  string       m_tag = "";

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] ins, input logic [39:0] a0, a1,
                       input logic [15:0] x0, x1, input string over);
    logic [15:0] dm, om, xh, r;
    bit legal;
    string tag;
    dm = ins[8] ? a1[31:16] : a0[31:16];
    om = ins[8] ? a0[31:16] : a1[31:16];
    xh = ins[9] ? x1 : x0;
    legal = 1; r = 0; tag = "R7";
    if (ins[15:12] != 4'b0011) legal = 0;
    else if (!ins[7]) begin
      if (ins[11:10] == 2'b00) begin r = dm ^ xh; tag = "R1"; end
      else if (ins[11:10] == 2'b01) begin r = dm & xh; tag = "R1"; end
      else if (ins[11:10] == 2'b10) begin r = dm | xh; tag = "R1"; end
      else begin r = ins[9] ? (dm | om) : (dm & om); tag = "R2"; end
    end else if (ins[11:10] == 2'b00) begin
      r = ins[9] ? ~dm : (dm ^ om); tag = "R3";
    end else legal = 0;
    if (over != "") tag = over;
    m_have = 1; m_tag = tag;
    m_wr = legal; m_ill = !legal;
    m_dst = legal ? ins[8] : 1'b0;
    if (legal) m_acc = ins[8] ? {a1[39:32], r, a1[15:0]} : {a0[39:32], r, a0[15:0]};
    else m_acc = '0;
    m_z = legal && (r == 0);
    m_s = legal && r[15];
  endtask

  task automatic step(input logic [15:0] ins, input logic [39:0] a0, a1,
                      input logic [15:0] x0, x1, input bit iv, input bit ordy, input string over);
    bit exp_rdy;
    @(negedge clk);
    check("R8 out_valid", out_valid, m_have);
    if (m_have) begin
      check({m_tag, " mid"}, out_acc[31:16], m_acc[31:16]);
      check("R5 edges", {out_acc[39:32], out_acc[15:0]}, {m_acc[39:32], m_acc[15:0]});
      check("R5 wr/dst", {out_wr, out_dst}, {m_wr, m_dst});
      check("R7 illegal", out_illegal, m_ill);
      check("R6 flags", {out_zero, out_sign, out_carry, out_ovf}, {m_z, m_s, 2'b00});
    end
    in_instr = ins; in_acc0 = a0; in_acc1 = a1; in_ax0_hi = x0; in_ax1_hi = x1;
    in_valid = iv; out_ready = ordy;
    #1;
    exp_rdy = !m_have || ordy;
    check("R9 in_ready", in_ready, exp_rdy);
    if (iv && exp_rdy) model(ins, a0, a1, x0, x1, over);
    else if (m_have && ordy) m_have = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [39:0] A0, A1;
    logic [15:0] X0, X1;
    A0 = 40'hA5_1234_5678; A1 = 40'h3C_F0F0_9ABC; X0 = 16'h00FF; X1 = 16'h8001;
    repeat (3) @(negedge clk);
    check("R10 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", out_valid, 1'b0);
    // R1 secondary-register forms
    step(16'h3000, A0, A1, X0, X1, 1, 1, "");
    step(16'h3300, A0, A1, X0, X1, 1, 1, "");
    step(16'h3500, A0, A1, X0, X1, 1, 1, "");
    step(16'h3A00, A0, A1, X0, X1, 1, 1, "");
    // R2 cross forms
    step(16'h3C00, A0, A1, X0, X1, 1, 1, "");
    step(16'h3D00, A0, A1, X0, X1, 1, 1, "");
    step(16'h3E00, A0, A1, X0, X1, 1, 1, "");
    step(16'h3F00, A0, A1, X0, X1, 1, 1, "");
    // R3 xor-cross and invert
    step(16'h3080, A0, A1, X0, X1, 1, 1, "");
    step(16'h3180, A0, A1, X0, X1, 1, 1, "");
    step(16'h3280, A0, A1, X0, X1, 1, 1, "");
    step(16'h3380, A0, A1, X0, X1, 1, 1, "");
    // R4 extension bits set
    step(16'h307F, A0, A1, X0, X1, 1, 1, "R4");
    step(16'h3C55, A0, A1, X0, X1, 1, 1, "R4");
    step(16'h32FF, A0, A1, X0, X1, 1, 1, "R4");
    step(16'h3B2A, A0, A1, X0, X1, 1, 1, "R4");
    // R6 zero with non-zero top/bottom, sign result
    step(16'h3400, A0, A1, 16'h0000, X1, 1, 1, "R6");
    step(16'h3080, 40'hFF_7777_FFFF, 40'h01_7777_0001, X0, X1, 1, 1, "R6");
    step(16'h3280, 40'h00_0000_0000, A1, X0, X1, 1, 1, "R6");
    // R7 illegal codes
    step(16'h4000, A0, A1, X0, X1, 1, 1, "");
    step(16'h3480, A0, A1, X0, X1, 1, 1, "");
    step(16'h3C80, A0, A1, X0, X1, 1, 1, "");
    step(16'h3A80, A0, A1, X0, X1, 1, 1, "");
    step(16'h0000, A0, A1, X0, X1, 1, 1, "");
    // R9 stall then bubble
    step(16'h3000, A0, A1, X0, X1, 1, 0, "");
    step(16'h3F00, A0, A1, X0, X1, 1, 0, "");
    step(16'h3F00, A0, A1, X0, X1, 1, 1, "");
    step(16'h0000, A0, A1, X0, X1, 0, 1, "");
    // randomized traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins;
      ins = {4'h3, 12'($urandom)};
      if (($urandom % 8) == 0) ins = 16'($urandom);
      step(ins, {$urandom, 8'($urandom)}, {$urandom, 8'($urandom)},
           16'($urandom), 16'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0, "");
    end
    step(16'h0000, A0, A1, X0, X1, 0, 1, "");
    step(16'h0000, A0, A1, X0, X1, 0, 1, "");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule